// File: doc/BRIEF.md
# Credit-Based Inter-Core Message Unit

This unit lets one small processing core exchange fixed-size messages with its peers in a many-core network. Software composes an outgoing message by writing eight 32-bit payload words to staging registers and then writing the destination core number. The message is placed in a pool of sixteen outgoing buffers. It leaves on the network port only while the unit holds a credit for that destination, and each credit stands for one receive slot that the remote core has reserved.

On the receive side, software reserves slots ahead of time by writing the sending core's number to a posting register. Each posting returns one credit to that sender on a dedicated credit channel. Arriving messages fill the reserved slots in arrival order. A pending flag and a level interrupt stay high until software has acknowledged every filled slot. The head message's source and payload can be read through registers.

Both network directions use valid/ready. A beat moves only in a cycle where valid and ready are both high. The unit holds its outgoing beat unchanged while the network back-pressures, and it raises `rx_ready` only while it has a reserved slot that is still empty. The credit channels are plain one-cycle pulses with no back-pressure.

Top module: `msg_unit`

## Requirements
- R1: After reset, `tx_valid`, `rx_ready`, `crd_out_valid`, `send_full`, `send_err`, `rx_pend` and `irq` are low, the status register (read offset 12) reads zero, and every credit counter is zero.
- R2: Writes to offsets 0..7 stage payload words, and a write to offset 8 (destination number in the low bits) queues the message. The outgoing beat carries `tx_src` = own core number, `tx_dst`, and staged word k at `tx_payload[32k+31:32k]`, all in one beat.
- R3: While `tx_valid` is high and `tx_ready` is low, the beat (`tx_valid`, `tx_dst`, `tx_payload`) stays unchanged. A message counts as sent only in a cycle where both are high.
- R4: A message leaves only while the unit holds a credit for its destination. Each `crd_in_valid` pulse adds one credit for `crd_in_from`, and sending a message uses one. A counter never goes below zero and stops rising at the slot depth (4), so credits returned beyond that are lost.
- R5: The oldest queued message whose destination has a credit goes first. A message without a credit does not block messages for other destinations. Messages for the same destination always leave in the order they were queued.
- R6: The pool holds 16 messages. When all 16 are occupied, `send_full` and status bit 1 are high, and any further send is discarded. The occupancy count is readable at status bits 12:8.
- R7: A send addressed to the unit's own core number is not queued or transmitted. It sets `send_err` and status bit 2, which stay set until any write to offset 11.
- R8: A write to offset 9 (sender number in the low bits) reserves a slot and produces a one-cycle `crd_out_valid` pulse with `crd_out_to` equal to that sender. `rx_ready` is high while a reserved slot is still empty. A posting is ignored, with no pulse, when reserved plus filled slots already equal 4.
- R9: An arriving message sets `rx_pend` and `irq` and is readable with payload word k at offset k and the source at offset 8. A write to offset 10 releases the head slot. Slots are presented in arrival order, and both flags fall once all slots are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_ready | input | 1 | Network accepts outgoing beat |
| tx_src | output | IDW | Own core number |
| tx_dst | output | IDW | Destination core number |
| tx_payload | output | 256 | Eight payload words |
| rx_valid | input | 1 | Incoming beat valid |
| rx_ready | output | 1 | A reserved slot is free |
| rx_src | input | IDW | Source core of incoming beat |
| rx_payload | input | 256 | Incoming payload words |
| crd_in_valid | input | 1 | One credit returned to this unit |
| crd_in_from | input | IDW | Core that granted the credit |
| crd_out_valid | output | 1 | One credit sent to a peer |
| crd_out_to | output | IDW | Peer receiving the credit |
| send_full | output | 1 | Outgoing pool occupied |
| send_err | output | 1 | Sticky self-send error |
| rx_pend | output | 1 | At least one filled slot |
| irq | output | 1 | Level interrupt for filled slots |

## Verification
The hardest states to reach are a completely full outgoing pool and a credit counter sitting at its limit. Neither can happen while credits keep flowing. The stimulus therefore withholds credits for one destination while it queues sixteen messages and then a seventeenth. It holds `tx_ready` low while it returns six credits, and it then releases credits in measured rounds so that the exact number of departures shows both the refusal and the saturation. Skipping is exposed by blocking one destination behind another that holds a credit.

// File: rtl/msg_pkg.sv
package msg_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 8;
  localparam int PAY_W  = WORD_W * NWORDS;
  typedef logic [PAY_W-1:0] payload_t;

  // register offsets
  localparam logic [3:0] RA_SEND = 4'd8;   // write: destination, queues message
  localparam logic [3:0] RA_POST = 4'd9;   // write: reserve slot for sender
  localparam logic [3:0] RA_ACK  = 4'd10;  // write: release head slot
  localparam logic [3:0] RA_CLR  = 4'd11;  // write: clear self-send error
  localparam logic [3:0] RA_SRC  = 4'd8;   // read: head slot source
  localparam logic [3:0] RA_STAT = 4'd12;  // read: status
endpackage

// File: rtl/msg_credit_bank.sv
module msg_credit_bank #(
  parameter int NCORES = 4,
  parameter int SLOTS  = 4,
  localparam int IDW   = $clog2(NCORES),
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_valid,
  input  logic [IDW-1:0]    inc_id,
  input  logic              take_valid,
  input  logic [IDW-1:0]    take_id,
  output logic [NCORES-1:0] avail
);
  for (genvar d = 0; d < NCORES; d++) begin : g_cr
    logic [CW-1:0] cnt, nxt;
    logic ic, tk;
    assign ic = inc_valid && (inc_id == IDW'(d));
    assign tk = take_valid && (take_id == IDW'(d));

    always_comb begin
      nxt = cnt - CW'(tk);
      if (ic && nxt < CW'(SLOTS)) nxt = nxt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
    end

    assign avail[d] = (cnt != '0);

    // R4
    take_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tk |-> cnt != '0);
    // R4
    credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(SLOTS));
  end
endmodule

// File: rtl/msg_send_pool.sv
module msg_send_pool import msg_pkg::*; #(
  parameter int NCORES  = 4,
  parameter int NBUF    = 16,
  parameter int SELF_ID = 0,
  localparam int IDW    = $clog2(NCORES),
  localparam int SELW   = $clog2(NBUF),
  localparam int CNTW   = $clog2(NBUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [IDW-1:0]    push_dst,
  input  payload_t          push_pay,
  input  logic [NCORES-1:0] avail,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [IDW-1:0]    tx_dst,
  output payload_t          tx_pay,
  output logic              take_valid,
  output logic [IDW-1:0]    take_id,
  output logic [CNTW-1:0]   count,
  output logic              full
);
  logic [IDW-1:0] dst_q [NBUF];
  payload_t       pay_q [NBUF];
  logic [IDW-1:0] nd [NBUF];
  payload_t       np [NBUF];
  logic [CNTW-1:0] cnt, ncnt;
  logic [SELW-1:0] sel;
  logic found, load, push_ok;

  // oldest eligible entry: index 0 is the oldest
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (CNTW'(i) < cnt && avail[dst_q[i]]) begin
        found = 1'b1;
        sel   = SELW'(i);
      end
    end
  end

  assign full    = (cnt == CNTW'(NBUF));
  assign push_ok = push_req && !full;
  assign load    = found && (!tx_valid || tx_ready);

  always_comb begin
    nd   = dst_q;
    np   = pay_q;
    ncnt = cnt;
    if (load) begin
      for (int i = 0; i < NBUF - 1; i++) begin
        if (SELW'(i) >= sel) begin
          nd[i] = dst_q[i+1];
          np[i] = pay_q[i+1];
        end
      end
      ncnt = ncnt - 1'b1;
    end
    if (push_ok) begin
      for (int i = 0; i < NBUF; i++) begin
        if (CNTW'(i) == ncnt) begin
          nd[i] = push_dst;
          np[i] = push_pay;
        end
      end
      ncnt = ncnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    dst_q <= nd;
    pay_q <= np;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tx_valid <= 1'b0;
      tx_dst   <= '0;
      tx_pay   <= '0;
    end else begin
      cnt <= ncnt;
      if (load) begin
        tx_valid <= 1'b1;
        tx_dst   <= dst_q[sel];
        tx_pay   <= pay_q[sel];
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end

  assign take_valid = load;
  assign take_id    = dst_q[sel];
  assign count      = cnt;

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_dst) && $stable(tx_pay));
  // R6
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(NBUF));
  // R7
  no_self_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_dst != IDW'(SELF_ID));
endmodule

// File: rtl/msg_rx_slots.sv
module msg_rx_slots import msg_pkg::*; #(
  parameter int NCORES = 4,
  parameter int SLOTS  = 4,
  localparam int IDW   = $clog2(NCORES),
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           post_req,
  input  logic [IDW-1:0] post_from,
  input  logic           ack,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [IDW-1:0] rx_src,
  input  payload_t       rx_pay,
  output logic           crd_valid,
  output logic [IDW-1:0] crd_to,
  output logic [IDW-1:0] head_src,
  output payload_t       head_pay,
  output logic           pending
);
  logic [IDW-1:0] src_m [SLOTS];
  payload_t       pay_m [SLOTS];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  fcnt, pfree;
  logic post_ok, rxhs, pop;

  assign post_ok  = post_req && ({1'b0, fcnt} + {1'b0, pfree} < (CW+1)'(SLOTS));
  assign rx_ready = (pfree != '0);
  assign rxhs     = rx_valid && rx_ready;
  assign pop      = ack && (fcnt != '0);
  assign pending  = (fcnt != '0);
  assign head_src = src_m[rp];
  assign head_pay = pay_m[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rxhs) begin
      src_m[wp] <= rx_src;
      pay_m[wp] <= rx_pay;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      fcnt      <= '0;
      pfree     <= '0;
      crd_valid <= 1'b0;
      crd_to    <= '0;
    end else begin
      if (rxhs) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      fcnt      <= fcnt + CW'(rxhs) - CW'(pop);
      pfree     <= pfree + CW'(post_ok) - CW'(rxhs);
      crd_valid <= post_ok;
      if (post_ok) crd_to <= post_from;
    end
  end

  // R8
  slot_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fcnt} + {1'b0, pfree} <= (CW+1)'(SLOTS));
  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !ack |=> pending && $stable(head_src) && $stable(head_pay));
endmodule

// File: rtl/msg_unit.sv
module msg_unit import msg_pkg::*; #(
  parameter int NCORES  = 4,
  parameter int SELF_ID = 1,
  parameter int NBUF    = 16,
  parameter int SLOTS   = 4,
  localparam int IDW    = $clog2(NCORES),
  localparam int CNTW   = $clog2(NBUF + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic [3:0]     reg_rd_addr,
  output logic [31:0]    reg_rdata,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [IDW-1:0] tx_src,
  output logic [IDW-1:0] tx_dst,
  output logic [255:0]   tx_payload,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [IDW-1:0] rx_src,
  input  logic [255:0]   rx_payload,
  input  logic           crd_in_valid,
  input  logic [IDW-1:0] crd_in_from,
  output logic           crd_out_valid,
  output logic [IDW-1:0] crd_out_to,
  output logic           send_full,
  output logic           send_err,
  output logic           rx_pend,
  output logic           irq
);
  localparam logic [IDW-1:0] ME = IDW'(SELF_ID);

  logic [WORD_W-1:0] stage [NWORDS];
  payload_t          push_pay, head_pay;
  logic [IDW-1:0]    wr_id, take_id, head_src;
  logic              send_wr, push_req, take_valid, pending;
  logic [NCORES-1:0] avail;
  logic [CNTW-1:0]   occ;

  assign wr_id    = reg_wdata[IDW-1:0];
  assign send_wr  = reg_wr_en && (reg_addr == RA_SEND);
  assign push_req = send_wr && (wr_id != ME);

  always_comb begin
    for (int k = 0; k < NWORDS; k++) push_pay[k*WORD_W +: WORD_W] = stage[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NWORDS; k++) stage[k] <= '0;
      send_err <= 1'b0;
    end else begin
      if (reg_wr_en && !reg_addr[3]) stage[reg_addr[2:0]] <= reg_wdata;
      if (send_wr && wr_id == ME)                 send_err <= 1'b1;
      else if (reg_wr_en && reg_addr == RA_CLR)   send_err <= 1'b0;
    end
  end

  msg_credit_bank #(.NCORES(NCORES), .SLOTS(SLOTS)) u_credit (
    .clk, .rst_n,
    .inc_valid(crd_in_valid), .inc_id(crd_in_from),
    .take_valid, .take_id, .avail
  );

  msg_send_pool #(.NCORES(NCORES), .NBUF(NBUF), .SELF_ID(SELF_ID)) u_pool (
    .clk, .rst_n,
    .push_req, .push_dst(wr_id), .push_pay,
    .avail, .tx_ready, .tx_valid, .tx_dst, .tx_pay(tx_payload),
    .take_valid, .take_id, .count(occ), .full(send_full)
  );

  msg_rx_slots #(.NCORES(NCORES), .SLOTS(SLOTS)) u_rx (
    .clk, .rst_n,
    .post_req(reg_wr_en && reg_addr == RA_POST), .post_from(wr_id),
    .ack(reg_wr_en && reg_addr == RA_ACK),
    .rx_valid, .rx_ready, .rx_src, .rx_pay(rx_payload),
    .crd_valid(crd_out_valid), .crd_to(crd_out_to),
    .head_src, .head_pay, .pending
  );

  assign tx_src  = ME;
  assign rx_pend = pending;
  assign irq     = pending;

  always_comb begin
    reg_rdata = '0;
    if (!reg_rd_addr[3]) begin
      reg_rdata = head_pay[{reg_rd_addr[2:0], 5'b0} +: WORD_W];
    end else if (reg_rd_addr == RA_SRC) begin
      reg_rdata[IDW-1:0] = head_src;
    end else if (reg_rd_addr == RA_STAT) begin
      reg_rdata[2:0]     = {send_err, send_full, pending};
      reg_rdata[8 +: CNTW] = occ;
    end
  end

  // R7
  self_send_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_wr && wr_id == ME |=> send_err);
endmodule

// File: tb/msg_unit_test.sv
module msg_unit_test;
  localparam int NC = 4, ME = 1, NB = 16, SL = 4, IDW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_wr_en, tx_valid, tx_ready, rx_valid, rx_ready;
  logic crd_in_valid, crd_out_valid, send_full, send_err, rx_pend, irq;
  logic [3:0] reg_addr, reg_rd_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [IDW-1:0] tx_src, tx_dst, rx_src, crd_in_from, crd_out_to;
  logic [255:0] tx_payload, rx_payload;

  msg_unit #(.NCORES(NC), .SELF_ID(ME), .NBUF(NB), .SLOTS(SL)) uut (
    .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .reg_rd_addr, .reg_rdata,
    .tx_valid, .tx_ready, .tx_src, .tx_dst, .tx_payload,
    .rx_valid, .rx_ready, .rx_src, .rx_payload,
    .crd_in_valid, .crd_in_from, .crd_out_valid, .crd_out_to,
    .send_full, .send_err, .rx_pend, .irq
  );

  int checks = 0, fails = 0;
  logic [259:0] exp_q[$];
  string tag_q[$];

  function automatic logic [255:0] mkpay(input int base);
    logic [255:0] p;
    for (int k = 0; k < 8; k++) p[k*32 +: 32] = 32'(base + k);
    return p;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk); #1;
    if (tx_valid && tx_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected beat: actual dst %0d expected none", tx_dst);
      end else begin
        logic [259:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({tx_src, tx_dst, tx_payload} !== e) begin
          fails++;
          $display("FAIL %s beat: actual %0h expected %0h", t, {tx_src, tx_dst, tx_payload}, e);
        end
      end
    end
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input int dst, input int base);
    for (int k = 0; k < 8; k++) wr(4'(k), 32'(base + k));
    wr(4'd8, 32'(dst));
  endtask

  task automatic expect_msg(input int dst, input int base, input string tag);
    exp_q.push_back({2'(ME), 2'(dst), mkpay(base)});
    tag_q.push_back(tag);
  endtask

  task automatic credit(input int from, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); crd_in_valid = 1'b1; crd_in_from = 2'(from);
    end
    @(negedge clk); crd_in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 300 && exp_q.size() != 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(tag, "expected beats left", 64'(exp_q.size()), 0);
  endtask

  task automatic arrive(input int src, input int base);
    @(negedge clk);
    chk("R8", "rx_ready before arrival", 64'(rx_ready), 1);
    rx_valid = 1'b1; rx_src = 2'(src); rx_payload = mkpay(base);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [255:0] held;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; reg_rd_addr = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_src = '0; rx_payload = '0;
    crd_in_valid = 1'b0; crd_in_from = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd12, d);
    chk("R1", "status", 64'(d), 0);
    chk("R1", "tx_valid", 64'(tx_valid), 0);
    chk("R1", "rx_ready", 64'(rx_ready), 0);
    chk("R1", "flags", 64'({crd_out_valid, send_full, send_err, rx_pend, irq}), 0);

    // R2 basic send with one credit
    credit(2, 1);
    tx_ready = 1'b1;
    expect_msg(2, 32'h100, "R2");
    send(2, 32'h100);
    drain("R2");

    // R4 no credit: message waits
    expect_msg(2, 32'h200, "R4");
    send(2, 32'h200);
    repeat (10) @(negedge clk);
    chk("R4", "tx_valid without credit", 64'(tx_valid), 0);
    credit(2, 1);
    drain("R4");

    // R3 stall holds beat
    tx_ready = 1'b0;
    credit(3, 1);
    expect_msg(3, 32'h300, "R3");
    send(3, 32'h300);
    repeat (3) @(negedge clk);
    chk("R3", "tx_valid stalled", 64'(tx_valid), 1);
    held = tx_payload;
    repeat (4) @(negedge clk);
    chk("R3", "dst held", 64'(tx_dst), 3);
    chk("R3", "payload held", 64'(tx_payload == held), 1);
    tx_ready = 1'b1;
    drain("R3");

    // R4 saturation: six credits, only four usable
    tx_ready = 1'b0;
    credit(0, 6);
    for (int i = 0; i < 6; i++) send(0, 32'h400 + 16 * i);
    for (int i = 0; i < 4; i++) expect_msg(0, 32'h400 + 16 * i, "R4");
    tx_ready = 1'b1;
    drain("R4");
    chk("R4", "saturated credits exhausted", 64'(tx_valid), 0);
    for (int i = 4; i < 6; i++) expect_msg(0, 32'h400 + 16 * i, "R4");
    credit(0, 2);
    drain("R4");

    // R5 skip blocked destination, keep per-destination order
    credit(3, 1);
    expect_msg(3, 32'h600, "R5");
    send(2, 32'h500);
    send(3, 32'h600);
    drain("R5");
    expect_msg(2, 32'h500, "R5");
    expect_msg(2, 32'h700, "R5");
    send(2, 32'h700);
    credit(2, 2);
    drain("R5");

    // R6 pool of sixteen
    tx_ready = 1'b0;
    for (int i = 0; i < 16; i++) send(0, 32'h1000 + 16 * i);
    rd(4'd12, d);
    chk("R6", "send_full", 64'(send_full), 1);
    chk("R6", "status full bit", 64'(d[1]), 1);
    chk("R6", "occupancy", 64'(d[12:8]), 16);
    send(0, 32'h9000);
    rd(4'd12, d);
    chk("R6", "occupancy after refusal", 64'(d[12:8]), 16);
    for (int i = 0; i < 16; i++) expect_msg(0, 32'h1000 + 16 * i, "R6");
    tx_ready = 1'b1;
    for (int r = 0; r < 4; r++) begin
      credit(0, 4);
      for (int n = 0; n < 100 && exp_q.size() > 12 - 4 * r; n++) @(negedge clk);
    end
    drain("R6");
    credit(0, 1);
    repeat (15) @(negedge clk);
    chk("R6", "refused message absent", 64'(tx_valid), 0);
    chk("R6", "send_full cleared", 64'(send_full), 0);

    // R7 self-send
    send(ME, 32'hA00);
    rd(4'd12, d);
    chk("R7", "send_err", 64'(send_err), 1);
    chk("R7", "status err bit", 64'(d[2]), 1);
    chk("R7", "not queued", 64'(d[12:8]), 0);
    repeat (10) @(negedge clk);
    chk("R7", "no beat", 64'(tx_valid), 0);
    wr(4'd11, 0);
    chk("R7", "err cleared", 64'(send_err), 0);

    // R8 posting and credit return
    wr(4'd9, 2);
    chk("R8", "credit pulse", 64'({crd_out_valid, crd_out_to}), {1'b1, 2'd2});
    @(negedge clk);
    chk("R8", "pulse one cycle", 64'(crd_out_valid), 0);
    chk("R8", "rx_ready after post", 64'(rx_ready), 1);
    wr(4'd9, 0); chk("R8", "credit to 0", 64'({crd_out_valid, crd_out_to}), {1'b1, 2'd0});
    wr(4'd9, 3); chk("R8", "credit to 3", 64'({crd_out_valid, crd_out_to}), {1'b1, 2'd3});
    wr(4'd9, 2); chk("R8", "credit to 2", 64'({crd_out_valid, crd_out_to}), {1'b1, 2'd2});
    wr(4'd9, 0); chk("R8", "fifth post ignored", 64'(crd_out_valid), 0);

    // R9 arrivals
    arrive(2, 32'hB00);
    rd(4'd8, d);
    chk("R9", "pending and irq", 64'({rx_pend, irq}), 2'b11);
    chk("R9", "head source", 64'(d), 2);
    rd(4'd7, d);
    chk("R9", "head word 7", 64'(d), 32'hB07);
    arrive(0, 32'hC00);
    arrive(3, 32'hD00);
    arrive(2, 32'hE00);
    @(negedge clk);
    chk("R8", "rx_ready with all slots filled", 64'(rx_ready), 0);
    wr(4'd9, 1);
    chk("R8", "post with slots filled ignored", 64'(crd_out_valid), 0);
    rd(4'd0, d); chk("R9", "first word 0", 64'(d), 32'hB00);
    wr(4'd10, 0);
    rd(4'd8, d); chk("R9", "second source", 64'(d), 0);
    rd(4'd3, d); chk("R9", "second word 3", 64'(d), 32'hC03);
    wr(4'd9, 1);
    chk("R8", "post after release", 64'({crd_out_valid, crd_out_to}), {1'b1, 2'd1});
    wr(4'd10, 0);
    rd(4'd8, d); chk("R9", "third source", 64'(d), 3);
    wr(4'd10, 0);
    rd(4'd5, d); chk("R9", "fourth word 5", 64'(d), 32'hE05);
    wr(4'd10, 0);
    chk("R9", "flags cleared", 64'({rx_pend, irq}), 0);
    rd(4'd12, d); chk("R9", "status pending bit", 64'(d[0]), 0);

    repeat (5) @(negedge clk);
    chk("R4", "no stray beats", 64'(exp_q.size()), 0);
    report();
  end
endmodule